// File: doc/BRIEF.md
# Dual-Byte Latched Bidirectional Transceiver

The block moves data between two 16-bit port groups, A and B, split into two byte lanes that work independently. In each lane, data can flow from A to B and from B to A. Each direction has its own byte of storage and three active-low controls: an enable, a latch enable and an output enable. Software or a neighbouring controller can therefore steer, hold or isolate either byte on its own.

The bidirectional pins are modelled as three separate vectors per port group: an input vector, an output vector and a per-bit drive-enable vector. Each direction in each lane runs a small state machine. At every clock edge it samples its three controls and registers a mode. The storage updates on every edge while the registered mode is transparent, and it keeps its value otherwise.

The destination port drives only in two modes. In PASS it drives the current source data, which reaches the output combinationally. In REPLAY it drives the stored byte. The states are:
- ISOLATED: enable is high.
- TRACK_QUIET: enable low, latch enable low, output enable high.
- HOLD_QUIET: enable low, latch enable high, output enable high.
- PASS: all three controls low.
- REPLAY: enable and output enable low, latch enable high.

Any state can move to any other. The next state is decoded from the controls sampled at the edge, and enable has priority over the other two controls. Reset puts every direction in ISOLATED and clears the storage to zero.

Top module: `dual_byte_xcvr`

## Requirements
- R1: During and after reset all drive-enable bits are 0. The stored byte of every direction reads back as 0x00 when first replayed.
- R2: While a direction's enable is 1, its destination drive-enable bits are 0 one cycle later and its stored byte is left unchanged, whatever the other two controls are.
- R3: While output enable is 1, the destination is not driven. If enable and latch enable are both 0 in that cycle, the storage still tracks the source.
- R4: With enable, latch enable and output enable all 0, the destination drives the current source byte. A source change is visible without waiting for a clock edge.
- R5: With enable and output enable 0 and latch enable 1, the destination drives the stored byte, and source changes have no effect on it.
- R6: The stored byte equals the source value present at the clock edge that first samples latch enable high after a transparent cycle.
- R7: B-to-A flow behaves like A-to-B flow, using its own three controls, with the B input as source and the A output as destination.
- R8: Lane 0 owns bits 7:0 and lane 1 owns bits 15:8. The controls of one lane never change the other lane's outputs.
- R9: Any output bit whose drive-enable bit is 0 reads 0.
- R10: A control change takes effect on the outputs one clock edge after it is sampled. Before that edge, the outputs keep their previous mode.
- R11: A lane drives both its A and B ports at the same time only if both of its directions were enabled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 16 | A port values seen on the pins |
| a_out | output | 16 | A port drive values (B-to-A flow) |
| a_oe | output | 16 | A port per-bit drive enable |
| b_in | input | 16 | B port values seen on the pins |
| b_out | output | 16 | B port drive values (A-to-B flow) |
| b_oe | output | 16 | B port per-bit drive enable |
| ab_en_n | input | 2 | A-to-B enable per lane, active low |
| ab_le_n | input | 2 | A-to-B latch enable per lane, active low |
| ab_oe_n | input | 2 | A-to-B output enable per lane, active low |
| ba_en_n | input | 2 | B-to-A enable per lane, active low |
| ba_le_n | input | 2 | B-to-A latch enable per lane, active low |
| ba_oe_n | input | 2 | B-to-A output enable per lane, active low |

## Verification
The hardest case to reach from the ports is a capture that happens while the destination is not driven. In that case nothing is visible when the latch closes. The stimulus tracks a byte with output enable high and then closes the latch. It changes the source and only afterwards opens the output, so the replayed byte can only come from the hidden capture. The bench uses the same approach for the enable-high case: it shows the storage was untouched by replaying it once enable returns low.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [2:0] {
        DIR_ISOLATED    = 3'd0,
        DIR_TRACK_QUIET = 3'd1,
        DIR_HOLD_QUIET  = 3'd2,
        DIR_PASS        = 3'd3,
        DIR_REPLAY      = 3'd4
    } dir_state_t;

    // Enable outranks output enable, which outranks latch enable.
    function automatic dir_state_t decode_mode(input logic en_n,
                                               input logic le_n,
                                               input logic oe_n);
        dir_state_t m;
        if (en_n)
            m = DIR_ISOLATED;
        else if (oe_n)
            m = le_n ? DIR_HOLD_QUIET : DIR_TRACK_QUIET;
        else
            m = le_n ? DIR_REPLAY : DIR_PASS;
        return m;
    endfunction

    function automatic logic mode_is_transparent(input dir_state_t m);
        return (m == DIR_TRACK_QUIET) || (m == DIR_PASS);
    endfunction

endpackage

// File: rtl/xcvr_dir.sv
module xcvr_dir
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             le_n,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst_out,
    output logic [WIDTH-1:0] dst_oe
);

    dir_state_t       state_q;
    dir_state_t       state_d;
    logic [WIDTH-1:0] held_q;

    always_comb begin
        state_d = decode_mode(en_n, le_n, oe_n);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= DIR_ISOLATED;
        else
            state_q <= state_d;
    end

    // Storage follows the source while the registered mode is transparent
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (mode_is_transparent(state_q))
            held_q <= src;
    end

    // Output process
    always_comb begin
        dst_out = '0;
        dst_oe  = '0;
        unique case (state_q)
            DIR_ISOLATED,
            DIR_TRACK_QUIET,
            DIR_HOLD_QUIET: begin
                dst_out = '0;
                dst_oe  = '0;
            end
            DIR_PASS: begin
                dst_out = src;
                dst_oe  = '1;
            end
            DIR_REPLAY: begin
                dst_out = held_q;
                dst_oe  = '1;
            end
            default: begin
                dst_out = '0;
                dst_oe  = '0;
            end
        endcase
    end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    input  logic             ab_en_n,
    input  logic             ab_le_n,
    input  logic             ab_oe_n,
    input  logic             ba_en_n,
    input  logic             ba_le_n,
    input  logic             ba_oe_n
);

    xcvr_dir #(.WIDTH(WIDTH)) u_ab (
        .clk(clk), .rst_n(rst_n),
        .en_n(ab_en_n), .le_n(ab_le_n), .oe_n(ab_oe_n),
        .src(a_in), .dst_out(b_out), .dst_oe(b_oe)
    );

    xcvr_dir #(.WIDTH(WIDTH)) u_ba (
        .clk(clk), .rst_n(rst_n),
        .en_n(ba_en_n), .le_n(ba_le_n), .oe_n(ba_oe_n),
        .src(b_in), .dst_out(a_out), .dst_oe(a_oe)
    );

endmodule

// File: rtl/dual_byte_xcvr.sv
module dual_byte_xcvr #(
    parameter int LANES    = 2,
    parameter int LANE_W   = 8,
    localparam int TOTAL_W = LANES * LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TOTAL_W-1:0] a_in,
    output logic [TOTAL_W-1:0] a_out,
    output logic [TOTAL_W-1:0] a_oe,
    input  logic [TOTAL_W-1:0] b_in,
    output logic [TOTAL_W-1:0] b_out,
    output logic [TOTAL_W-1:0] b_oe,
    input  logic [LANES-1:0]   ab_en_n,
    input  logic [LANES-1:0]   ab_le_n,
    input  logic [LANES-1:0]   ab_oe_n,
    input  logic [LANES-1:0]   ba_en_n,
    input  logic [LANES-1:0]   ba_le_n,
    input  logic [LANES-1:0]   ba_oe_n
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        xcvr_lane #(.WIDTH(LANE_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .a_in   (a_in [l*LANE_W +: LANE_W]),
            .a_out  (a_out[l*LANE_W +: LANE_W]),
            .a_oe   (a_oe [l*LANE_W +: LANE_W]),
            .b_in   (b_in [l*LANE_W +: LANE_W]),
            .b_out  (b_out[l*LANE_W +: LANE_W]),
            .b_oe   (b_oe [l*LANE_W +: LANE_W]),
            .ab_en_n(ab_en_n[l]),
            .ab_le_n(ab_le_n[l]),
            .ab_oe_n(ab_oe_n[l]),
            .ba_en_n(ba_en_n[l]),
            .ba_le_n(ba_le_n[l]),
            .ba_oe_n(ba_oe_n[l])
        );
    end

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int LANES    = 2,
    parameter int LANE_W   = 8,
    localparam int TOTAL_W = LANES * LANE_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [TOTAL_W-1:0] a_out,
    input logic [TOTAL_W-1:0] a_oe,
    input logic [TOTAL_W-1:0] b_out,
    input logic [TOTAL_W-1:0] b_oe,
    input logic [LANES-1:0]   ab_en_n,
    input logic [LANES-1:0]   ab_le_n,
    input logic [LANES-1:0]   ab_oe_n,
    input logic [LANES-1:0]   ba_en_n,
    input logic [LANES-1:0]   ba_le_n,
    input logic [LANES-1:0]   ba_oe_n
);

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        localparam int LO = l * LANE_W;

        assert_en_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ab_en_n[l] |=> (b_oe[LO +: LANE_W] == '0));

        assert_oe_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ab_oe_n[l] |=> (b_oe[LO +: LANE_W] == '0));

        assert_ba_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ba_en_n[l] || ba_oe_n[l]) |=> (a_oe[LO +: LANE_W] == '0));

        assert_replay_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!ab_en_n[l] && ab_le_n[l] && !ab_oe_n[l] &&
             $past(!ab_en_n[l] && ab_le_n[l] && !ab_oe_n[l]) && b_oe[LO])
            |=> $stable(b_out[LO +: LANE_W]));

        assert_both_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (a_oe[LO] && b_oe[LO]) |-> $past(!ab_en_n[l] && !ba_en_n[l]));
    end

    assert_undriven_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (((a_out & ~a_oe) == '0) && ((b_out & ~b_oe) == '0)));

endmodule

bind dual_byte_xcvr xcvr_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_xcvr_checker (
    .clk(clk), .rst_n(rst_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
);

// File: tb/test_dual_byte_xcvr.sv
module test_dual_byte_xcvr;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [15:0] a_out, a_oe, b_out, b_oe;
    logic [1:0]  ab_en_n = '1, ab_le_n = '1, ab_oe_n = '1;
    logic [1:0]  ba_en_n = '1, ba_le_n = '1, ba_oe_n = '1;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_byte_xcvr i_dual_byte_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, then let one rising edge register the mode.
    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #2;
        chk("R1 a_oe in reset", a_oe, 16'h0000);
        chk("R1 b_oe in reset", b_oe, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
        settle();
        chk("R1 b_oe after reset", b_oe, 16'h0000);
        @(negedge clk);
        ab_en_n[0] = 0; ab_le_n[0] = 1; ab_oe_n[0] = 0;
        #1;
        chk("R10 no change before edge", b_oe, 16'h0000);
        settle();
        chk("R1 replay oe", b_oe, 16'h00FF);
        chk("R1 replay cleared", b_out, 16'h0000);
    endtask

    task automatic t_pass();
        @(negedge clk);
        a_in[7:0] = 8'h5A; ab_le_n[0] = 0;
        settle();
        chk("R4 pass", b_out, 16'h005A);
        a_in[7:0] = 8'hC3;
        #1;
        chk("R4 pass follows source", b_out, 16'h00C3);
    endtask

    task automatic t_capture();
        @(negedge clk);
        ab_le_n[0] = 1;
        settle();
        chk("R6 captured byte", b_out, 16'h00C3);
        a_in[7:0] = 8'h0F;
        #1;
        chk("R5 source ignored", b_out, 16'h00C3);
        settle();
        chk("R5 held over edge", b_out, 16'h00C3);
    endtask

    task automatic t_hidden();
        @(negedge clk);
        ab_oe_n[0] = 1; ab_le_n[0] = 0; a_in[7:0] = 8'h77;
        settle();
        chk("R3 not driven", b_oe, 16'h0000);
        chk("R9 undriven reads zero", b_out, 16'h0000);
        @(negedge clk); ab_le_n[0] = 1;
        settle();
        @(negedge clk); a_in[7:0] = 8'h00; ab_oe_n[0] = 0;
        settle();
        chk("R3 hidden capture", b_out, 16'h0077);
    endtask

    task automatic t_disabled();
        @(negedge clk);
        ab_en_n[0] = 1; ab_le_n[0] = 0; ab_oe_n[0] = 0; a_in[7:0] = 8'h99;
        settle();
        chk("R2 enable high quiet", b_oe, 16'h0000);
        @(negedge clk); ab_en_n[0] = 0; ab_le_n[0] = 1;
        settle();
        chk("R2 storage untouched", b_out, 16'h0077);
    endtask

    task automatic t_lanes();
        @(negedge clk);
        ab_en_n = 2'b01; ab_le_n = 2'b01; ab_oe_n = 2'b01; a_in[15:8] = 8'hA1;
        settle();
        chk("R8 lane1 only oe", b_oe, 16'hFF00);
        chk("R8 lane1 only data", b_out, 16'hA100);
    endtask

    task automatic t_reverse();
        @(negedge clk);
        ab_en_n = 2'b11; ab_le_n = 2'b11; ab_oe_n = 2'b11;
        ba_en_n = 2'b01; ba_le_n = 2'b01; ba_oe_n = 2'b01; b_in[15:8] = 8'h6B;
        settle();
        chk("R7 reverse pass", a_out, 16'h6B00);
        chk("R7 reverse oe", a_oe, 16'hFF00);
        @(negedge clk); ba_le_n[1] = 1;
        settle();
        b_in[15:8] = 8'h00;
        #1;
        chk("R7 reverse hold", a_out, 16'h6B00);
    endtask

    task automatic t_both();
        @(negedge clk);
        ba_en_n = 2'b10; ba_le_n = 2'b10; ba_oe_n = 2'b10; b_in[7:0] = 8'h12;
        ab_en_n = 2'b10; ab_le_n = 2'b11; ab_oe_n = 2'b10;
        settle();
        chk("R11 both oe a", a_oe, 16'h00FF);
        chk("R11 both oe b", b_oe, 16'h00FF);
        chk("R11 a data", a_out, 16'h0012);
        chk("R11 b data", b_out, 16'h0077);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_capture();
        t_hidden();
        t_disabled();
        t_lanes();
        t_reverse();
        t_both();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule